// File: doc/BRIEF.md
# Symbol-Rate Timing Loop Filter with Pulse-Density Output

This block closes the digital half of a symbol timing recovery loop. Once per symbol, marked by a strobe, it accepts a signed 12-bit timing error. It runs a second-order proportional-plus-integral filter whose two gains are powers of two selected by shift coefficients. The saturated 12-bit filter result is turned into a one-bit pulse-density stream by a first-order accumulator. After analog low-pass filtering, that stream steers an external oscillator running at twice the symbol rate.

A small register port configures the loop. A time-constant register holds the proportional shift, the integral shift and an output polarity bit, so the block can drive oscillators with either tuning slope. A read-only frequency register shows the upper bits of the integrator. Software reads it to see the frequency offset of the locked loop, which should sit near zero when the oscillator is centred.

Top module: `tmg_loop_pdm`

## Requirements
- R1: After a synchronous active-low reset, address 0x0C reads 0x45, address 0x0D reads 0x00, `pdm_out` is 0, and the integrator, the held filter result and the modulator accumulator are all zero.
- R2: A write to 0x0C stores all eight bits. In that register, bit 7 is the polarity, bits 6:4 are the proportional shift and bits 3:0 are the integral shift. Address 0x0D reads integrator bits 11:4 and ignores writes. Every other address reads 0x00 and ignores writes.
- R3: A proportional shift field of 0 acts as 1, and a field above 6 acts as 6. An integral shift field above 9 acts as 9. Reading the register back still returns the raw bits that were written.
- R4: On each strobe, the integrator adds the error arithmetically shifted right by the integral shift. The sum is saturated to the range -2048..2047.
- R5: On each strobe, the filter result becomes the saturated (-2048..2047) sum of two terms: the error arithmetically shifted right by the proportional shift, and the integrator value just updated.
- R6: On each strobe, a 12-bit accumulator adds the previous filter result plus 2048, taken modulo 4096. The carry out of that addition becomes the modulator bit, which is held until the next strobe.
- R7: When the polarity bit read at the strobe is 1, `pdm_out` is the inverse of the carry.
- R8: Without a strobe, the integrator, the accumulator and `pdm_out` keep their values, whatever the error input does.
- R9: A coefficient write takes effect at the first strobe after the write cycle. A strobe in the same cycle as the write still uses the old coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | One-cycle symbol strobe |
| err_in | input | 12 | Signed timing error, two's complement |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on address |
| pdm_out | output | 1 | Pulse-density output to the analog filter |

## Verification
The hardest situations to reach from the ports are the integrator pinned at either rail and the filter sum clipping while the integrator is not clipping. Both need large errors applied with the smallest shifts for many symbols. The stimulus sets the integral shift to zero and applies full-scale errors of each sign until the frequency register shows a rail. It then runs a random phase with small shifts, so that proportional and integral terms of opposite sign meet at the sum. The case of a write landing in the same cycle as a strobe is forced directly and told apart through the integrator value it leaves.

// File: rtl/tmg_pkg.sv
// Shared definitions for the timing loop filter: the time-constant
// register layout and the legal coefficient ranges.
package tmg_pkg;
    typedef struct packed {
        logic       pol;     // invert modulator output
        logic [2:0] pshift;  // proportional shift field
        logic [3:0] ishift;  // integral shift field
    } tc_reg_t;

    localparam int TC_BITS    = $bits(tc_reg_t);
    localparam int PSHIFT_MIN = 1;
    localparam int PSHIFT_MAX = 6;
    localparam int ISHIFT_MAX = 9;
endpackage

// File: rtl/tmg_regs.sv
// Register file for the timing loop.
// Holds the time-constant register and serves reads of it and of the
// integrator-based frequency register. Clamps the coefficient fields to
// their legal ranges for the datapath. Assumes DATA_W >= TC_BITS.
module tmg_regs
    import tmg_pkg::*;
#(
    parameter int              DATA_W  = 12,
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] TC_ADDR = 8'h0C,
    parameter logic [ADDR_W-1:0] FQ_ADDR = 8'h0D,
    parameter logic [TC_BITS-1:0] TC_RST = 8'h45
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [TC_BITS-1:0]       wdata,
    input  logic signed [DATA_W-1:0] integ,
    output logic [TC_BITS-1:0]       rdata,
    output logic                     pol,
    output logic [2:0]               pshift,
    output logic [3:0]               ishift
);
    tc_reg_t tc_q;

    // Time-constant register storage, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_q <= tc_reg_t'(TC_RST);
        else if (wr_en && addr == TC_ADDR)
            tc_q <= tc_reg_t'(wdata);
    end

    // Clamp coefficient fields to the supported ranges.
    always_comb begin
        pol = tc_q.pol;
        if (tc_q.pshift < 3'(PSHIFT_MIN))
            pshift = 3'(PSHIFT_MIN);
        else if (tc_q.pshift > 3'(PSHIFT_MAX))
            pshift = 3'(PSHIFT_MAX);
        else
            pshift = tc_q.pshift;
        ishift = (tc_q.ishift > 4'(ISHIFT_MAX)) ? 4'(ISHIFT_MAX) : tc_q.ishift;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        if (addr == TC_ADDR)
            rdata = tc_q;
        else if (addr == FQ_ADDR)
            rdata = integ[DATA_W-1 -: TC_BITS];
        else
            rdata = '0;
    end

    // R2
    tc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == TC_ADDR) |=> $stable(tc_q));
endmodule

// File: rtl/tmg_pi_filter.sv
// Proportional-plus-integral loop filter evaluated once per symbol strobe.
// The integrator adds err >>> ishift with saturation. The output is the
// saturated sum of err >>> pshift and the updated integrator.
// Assumes a one-cycle strobe and coefficients that are already clamped.
module tmg_pi_filter #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic signed [W-1:0] err,
    input  logic [2:0]          pshift,
    input  logic [3:0]          ishift,
    output logic signed [W-1:0] integ,
    output logic signed [W-1:0] filt
);
    localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] prop_term, int_step, integ_nx, filt_nx;
    logic        [W:0]   int_sum, out_sum;

    // Saturating add of two W-bit signed values.
    function automatic logic signed [W-1:0] sat_add(logic [W:0] s);
        if (s[W] != s[W-1])
            return s[W] ? SMIN : SMAX;
        else
            return s[W-1:0];
    endfunction

    // Shift terms and saturated integrator and output candidates.
    always_comb begin
        prop_term = err >>> pshift;
        int_step  = err >>> ishift;
        int_sum   = {integ[W-1], integ} + {int_step[W-1], int_step};
        integ_nx  = sat_add(int_sum);
        out_sum   = {prop_term[W-1], prop_term} + {integ_nx[W-1], integ_nx};
        filt_nx   = sat_add(out_sum);
    end

    // Update integrator and held output on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            filt  <= '0;
        end else if (stb) begin
            integ <= integ_nx;
            filt  <= filt_nx;
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (integ == '0 && filt == '0));
    // R8
    hold_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(integ) && $stable(filt)));
    // R4
    rail_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && integ == SMAX && !err[W-1]) |=> integ == SMAX);
    // R4
    rail_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && integ == SMIN && err[W-1]) |=> integ == SMIN);
endmodule

// File: rtl/tmg_pdm.sv
// First-order pulse-density modulator.
// On each strobe it adds the offset-binary form of the filter result to an
// accumulator and registers the carry, XORed with the polarity bit.
module tmg_pdm #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic signed [W-1:0] filt,
    input  logic                pol,
    output logic                pdm_out
);
    logic [W-1:0] acc_q;
    logic [W-1:0] level;
    logic [W:0]   acc_sum;

    // Offset-binary level and accumulator sum with carry.
    always_comb begin
        level   = {~filt[W-1], filt[W-2:0]};
        acc_sum = {1'b0, acc_q} + {1'b0, level};
    end

    // Advance accumulator and output bit once per symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            pdm_out <= 1'b0;
        end else if (stb) begin
            acc_q   <= acc_sum[W-1:0];
            pdm_out <= acc_sum[W] ^ pol;
        end
    end

    // R8
    hold_pdm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(pdm_out) && $stable(acc_q)));
    // R1
    rst_pdm_chk: assert property (@(posedge clk)
        !rst_n |=> (!pdm_out && acc_q == '0));
endmodule

// File: rtl/tmg_loop_pdm.sv
// Timing loop filter with pulse-density output: top level.
// Connects the register file, the PI filter and the modulator. The strobe
// marks one symbol. The filter result of a symbol feeds the modulator at
// the next strobe.
module tmg_loop_pdm
    import tmg_pkg::*;
#(
    parameter int                 DATA_W  = 12,
    parameter int                 ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  TC_ADDR = 8'h0C,
    parameter logic [ADDR_W-1:0]  FQ_ADDR = 8'h0D,
    parameter logic [TC_BITS-1:0] TC_RST  = 8'h45
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_stb,
    input  logic signed [DATA_W-1:0] err_in,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [TC_BITS-1:0]       reg_wdata,
    output logic [TC_BITS-1:0]       reg_rdata,
    output logic                     pdm_out
);
    logic                     pol;
    logic [2:0]               pshift;
    logic [3:0]               ishift;
    logic signed [DATA_W-1:0] integ, filt;

    tmg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .TC_ADDR(TC_ADDR), .FQ_ADDR(FQ_ADDR), .TC_RST(TC_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .integ(integ), .rdata(reg_rdata),
        .pol(pol), .pshift(pshift), .ishift(ishift)
    );

    tmg_pi_filter #(.W(DATA_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .stb(sym_stb), .err(err_in),
        .pshift(pshift), .ishift(ishift), .integ(integ), .filt(filt)
    );

    tmg_pdm #(.W(DATA_W)) u_pdm (
        .clk(clk), .rst_n(rst_n), .stb(sym_stb), .filt(filt),
        .pol(pol), .pdm_out(pdm_out)
    );

    // R6
    pdm_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(pdm_out) |-> $past(sym_stb));
endmodule

// File: tb/tmg_loop_pdm_test.sv
`timescale 1ns/100ps
module tmg_loop_pdm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_stb = 1'b0;
    logic [11:0] err_in = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h0D;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pdm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_tc, m_integ, m_filt, m_acc, m_pdm;

    tmg_loop_pdm uut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .err_in(err_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pdm_out(pdm_out)
    );

    always #2.5 clk = ~clk;

    function automatic int clip(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int model_read(int a);
        if (a == 8'h0C) return m_tc;
        if (a == 8'h0D) return (m_integ >>> 4) & 255;
        return 0;
    endfunction

    task automatic check(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model step on every edge, then compare outputs
    always @(posedge clk) begin
        int e, ps, is, pol, lvl;
        if (!rst_n) begin
            m_tc = 8'h45; m_integ = 0; m_filt = 0; m_acc = 0; m_pdm = 0;
        end else begin
            if (sym_stb) begin
                e   = $signed(err_in);
                pol = (m_tc >> 7) & 1;
                ps  = (m_tc >> 4) & 7;
                if (ps < 1) ps = 1;
                if (ps > 6) ps = 6;
                is  = m_tc & 15;
                if (is > 9) is = 9;
                lvl   = m_filt + 2048;
                m_acc = m_acc + lvl;
                m_pdm = ((m_acc >= 4096) ? 1 : 0) ^ pol;
                m_acc = m_acc % 4096;
                m_integ = clip(m_integ + (e >>> is));
                m_filt  = clip((e >>> ps) + m_integ);
            end
            if (reg_wr && reg_addr == 8'h0C) m_tc = reg_wdata;
        end
        #1;
        check(pdm_out, m_pdm, cur_req);
        check(reg_rdata, model_read(reg_addr), cur_req);
    end

    task automatic step(bit stb, int e);
        @(negedge clk);
        sym_stb = stb; err_in = 12'(e); reg_wr = 0; reg_addr = 8'h0D;
    endtask

    task automatic write_tc(bit stb, int e, int d);
        @(negedge clk);
        sym_stb = stb; err_in = 12'(e); reg_wr = 1; reg_addr = 8'h0C; reg_wdata = 8'(d);
    endtask

    task automatic peek(int a);
        @(negedge clk);
        sym_stb = 0; reg_wr = 0; reg_addr = 8'(a);
        #0.5;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; sym_stb = 0; reg_wr = 0;
        step(0, 0); step(0, 0);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        int held_fq;
        bit held_pdm;
        do_reset();
        // R1 reset state
        cur_req = "R1";
        peek(8'h0C); check(reg_rdata, 8'h45, "R1");
        peek(8'h0D); check(reg_rdata, 0, "R1");
        check(pdm_out, 0, "R1");
        // R2 read-only and unmapped addresses
        cur_req = "R2";
        @(negedge clk); reg_wr = 1; reg_addr = 8'h0D; reg_wdata = 8'hFF;
        @(negedge clk); reg_wr = 1; reg_addr = 8'h20; reg_wdata = 8'hAA;
        peek(8'h20); check(reg_rdata, 0, "R2");
        peek(8'h0C); check(reg_rdata, 8'h45, "R2");
        peek(8'h0D); check(reg_rdata, 0, "R2");
        // R6 modulator with zero error: carries alternate 0,1
        cur_req = "R6";
        step(1, 0); step(0, 0); check(pdm_out, 0, "R6");
        step(1, 0); step(0, 0); check(pdm_out, 1, "R6");
        // R4 positive then negative rail with integral shift 0
        cur_req = "R4";
        write_tc(0, 0, 8'h10);
        for (int i = 0; i < 6; i++) begin step(1, 2047); step(0, 0); end
        peek(8'h0D); check(reg_rdata, 8'h7F, "R4");
        for (int i = 0; i < 8; i++) begin step(1, -2048); step(0, 0); end
        peek(8'h0D); check(reg_rdata, 8'h80, "R4");
        // R5 random errors with small shifts, output clipping
        cur_req = "R5";
        for (int i = 0; i < 300; i++) begin
            step(1, $urandom_range(0, 4095) - 2048); step(0, 0);
        end
        // R8 no strobe: error moves, state holds
        cur_req = "R8";
        peek(8'h0D); held_fq = reg_rdata; held_pdm = pdm_out;
        for (int i = 0; i < 10; i++) step(0, i * 300 - 1500);
        peek(8'h0D);
        check(reg_rdata, held_fq, "R8");
        check(pdm_out, held_pdm, "R8");
        // R7 polarity: zero error after reset, first carry 0 reads as 1
        cur_req = "R7";
        do_reset();
        write_tc(0, 0, 8'hC5);
        step(1, 0); step(0, 0); check(pdm_out, 1, "R7");
        step(1, 0); step(0, 0); check(pdm_out, 0, "R7");
        for (int i = 0; i < 200; i++) begin
            step(1, $urandom_range(0, 1000) - 500); step(0, 0);
        end
        // R3 clamping: fields 0 and 15 act as 1 and 9; raw readback kept
        cur_req = "R3";
        do_reset();
        write_tc(0, 0, 8'h0F);
        peek(8'h0C); check(reg_rdata, 8'h0F, "R3");
        for (int i = 0; i < 32; i++) begin step(1, 2047); step(0, 0); end
        peek(8'h0D); check(reg_rdata, 6, "R3");
        write_tc(0, 0, 8'h7F);
        for (int i = 0; i < 100; i++) begin
            step(1, $urandom_range(0, 4095) - 2048); step(0, 0);
        end
        // R9 write in the same cycle as a strobe uses old coefficients
        cur_req = "R9";
        do_reset();
        write_tc(1, 320, 8'h10);
        step(0, 0);
        step(1, 320); step(0, 0);
        peek(8'h0D); check(reg_rdata, 20, "R9");
        // back-to-back strobes with interleaved writes
        for (int i = 0; i < 100; i++) begin
            if (i % 7 == 0) write_tc(1, $urandom_range(0, 4095) - 2048, $urandom_range(0, 255));
            else step(1, $urandom_range(0, 4095) - 2048);
        end
        step(0, 0); step(0, 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule